// File: doc/BRIEF.md
# Receive Packet Buffer with Burst Output

This block sits between a line demodulator and a host. The demodulator hands over one received bit at a time, each with a one-cycle strobe, at the slow line baud rate. In bit mode every received bit goes straight to the host. The host data line follows the bit, and the host clock line toggles once for each bit.

Packet mode needs two enables at once: a configuration bit and a pin driven by the host. In this mode the received bits are collected until a programmed count is reached. The collected packet then moves to a capture register and is sent to the host as a burst. The burst clock is derived from the master clock, so it runs far faster than the line rate.

While a burst is on its way out, the collector keeps taking in new bits. If the host pin drops during a session, the partly filled packet is discarded, any burst in progress is cut off, and delivery returns to one bit at a time.

Top module: `rx_pkt_buffer`

## Requirements
- R1: While reset is asserted and after it is released, `host_data` and `host_clk` are 0 and the collector is empty.
- R2: Packet mode is active only when `cfg_pkt_en` and `pin_pkt_en` are both 1. With either one at 0, bits are delivered in bit mode.
- R3: In bit mode, a received bit strobed at a clock edge appears on `host_data` at that edge, and `host_clk` inverts at that edge.
- R4: `cfg_len` selects the packet length: 0 gives 16 bits, 1 gives 14, 2 gives 9 and 3 gives 8. The collector's fill count always stays below the selected length.
- R5: The first bit strobed after packet mode becomes active is the first bit stored. Bits strobed earlier are delivered in bit mode.
- R6: A burst sends the packet's bits in the order they were received, oldest first. Each bit is valid on `host_data` when `host_clk` rises.
- R7: `cfg_rate` value r sets the burst bit period to 2^(r+1) master clock cycles, so successive rising edges of `host_clk` within a burst are exactly that far apart.
- R8: Bits that arrive while a burst is being sent are collected into the next packet, and none are lost.
- R9: When packet mode drops, the partial packet is discarded and any burst in progress is cut off. Later bits go out in bit mode, and the discarded bits never reach the host.
- R10: In packet mode, `host_clk` stays at 0 whenever no burst is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Demodulated received bit |
| rx_stb | input | 1 | One-cycle strobe marking a valid `rx_bit` |
| cfg_pkt_en | input | 1 | Configuration enable for packet mode |
| pin_pkt_en | input | 1 | Host pin enable for packet mode |
| cfg_len | input | 2 | Packet length select (16/14/9/8) |
| cfg_rate | input | 2 | Burst clock divide select |
| host_data | output | 1 | Serial data to the host |
| host_clk | output | 1 | Bit clock to the host |

## Verification
The bench goes after four corner cases.

- **Odd lengths of 9 and 14.** A design that aligns the packet wrongly would send stale or zero bits at the head of the burst.
- **Enable boundary.** A design that latches the enable one bit late would deliver the first packet bit in bit mode as well.
- **Pin dropped in the middle of a packet.** Without a flush, the discarded bits would leak into the next burst.
- **Bits arriving during a burst.** A single shared buffer would corrupt or drop them.

At every divide setting, the spacing between burst clock edges is measured. A wrong divider would show up as edge gaps that differ from 2^(r+1).

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;
  localparam int PKT_MAX = 16;
  localparam int CNT_W   = $clog2(PKT_MAX + 1);

  function automatic logic [CNT_W-1:0] pkt_len(input logic [1:0] sel);
    case (sel)
      2'd0:    pkt_len = CNT_W'(16);
      2'd1:    pkt_len = CNT_W'(14);
      2'd2:    pkt_len = CNT_W'(9);
      default: pkt_len = CNT_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/rxpk_collect.sv
module rxpk_collect
  import rxpk_pkg::*;
#(
  parameter int MAXLEN = PKT_MAX,
  parameter int CW     = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic              stb,
  input  logic              din,
  input  logic [CW-1:0]     len,
  output logic              load,
  output logic [MAXLEN-1:0] word,
  output logic [CW-1:0]     cnt
);
  logic [MAXLEN-1:0] sreg_q, sreg_shift, sreg_d;
  logic [CW-1:0]     cnt_d;
  logic              last;
  logic              en;

  always_comb begin
    sreg_shift = {sreg_q[MAXLEN-2:0], din};
    last       = (cnt == len - CW'(1));
    load       = mode & stb & last;
    word       = sreg_shift << (CW'(MAXLEN) - len);
    en         = stb | ~mode;
    sreg_d     = sreg_q;
    cnt_d      = cnt;
    if (!mode) begin
      cnt_d = '0;
    end else if (stb) begin
      sreg_d = sreg_shift;
      cnt_d  = last ? '0 : cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt    <= '0;
    end else if (en) begin
      sreg_q <= sreg_d;
      cnt    <= cnt_d;
    end
  end
endmodule

// File: rtl/rxpk_burst.sv
module rxpk_burst
  import rxpk_pkg::*;
#(
  parameter int MAXLEN = PKT_MAX,
  parameter int CW     = CNT_W,
  parameter int RATE_W = 2,
  localparam int PH_W  = 1 << RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic              load,
  input  logic [MAXLEN-1:0] word,
  input  logic [CW-1:0]     len,
  input  logic [RATE_W-1:0] rate,
  output logic              b_data,
  output logic              b_clk,
  output logic              busy
);
  logic [MAXLEN-1:0] cap_q, cap_d;
  logic [CW-1:0]     left_q, left_d;
  logic [PH_W-1:0]   ph_q, ph_d, half, ph_end;
  logic              busy_d;

  always_comb begin
    half   = PH_W'(1) << rate;
    ph_end = (half << 1) - PH_W'(1);
    b_clk  = busy & (ph_q >= half);
    b_data = busy & cap_q[MAXLEN-1];
    cap_d  = cap_q;
    left_d = left_q;
    ph_d   = ph_q;
    busy_d = busy;
    if (!mode) begin
      busy_d = 1'b0;
      ph_d   = '0;
    end else if (load) begin
      cap_d  = word;
      left_d = len;
      ph_d   = '0;
      busy_d = 1'b1;
    end else if (busy) begin
      if (ph_q == ph_end) begin
        ph_d   = '0;
        cap_d  = cap_q << 1;
        left_d = left_q - CW'(1);
        if (left_q == CW'(1)) busy_d = 1'b0;
      end else begin
        ph_d = ph_q + PH_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      left_q <= '0;
      ph_q   <= '0;
      busy   <= 1'b0;
    end else begin
      cap_q  <= cap_d;
      left_q <= left_d;
      ph_q   <= ph_d;
      busy   <= busy_d;
    end
  end
endmodule

// File: rtl/rx_pkt_buffer.sv
module rx_pkt_buffer
  import rxpk_pkg::*;
#(
  parameter int MAXLEN = PKT_MAX,
  parameter int RATE_W = 2,
  localparam int CW    = $clog2(MAXLEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  input  logic              rx_stb,
  input  logic              cfg_pkt_en,
  input  logic              pin_pkt_en,
  input  logic [1:0]        cfg_len,
  input  logic [RATE_W-1:0] cfg_rate,
  output logic              host_data,
  output logic              host_clk
);
  logic              mode;
  logic [CW-1:0]     len_dec;
  logic              load, busy, b_data, b_clk;
  logic [MAXLEN-1:0] word;
  logic [CW-1:0]     col_cnt;
  logic              data_d, clk_d, out_en;

  assign mode    = cfg_pkt_en & pin_pkt_en;
  assign len_dec = CW'(pkt_len(cfg_len));

  rxpk_collect #(.MAXLEN(MAXLEN), .CW(CW)) u_col (
    .clk(clk), .rst_n(rst_n), .mode(mode), .stb(rx_stb), .din(rx_bit),
    .len(len_dec), .load(load), .word(word), .cnt(col_cnt)
  );

  rxpk_burst #(.MAXLEN(MAXLEN), .CW(CW), .RATE_W(RATE_W)) u_bst (
    .clk(clk), .rst_n(rst_n), .mode(mode), .load(load), .word(word),
    .len(len_dec), .rate(cfg_rate), .b_data(b_data), .b_clk(b_clk),
    .busy(busy)
  );

  always_comb begin
    out_en = mode | rx_stb;
    if (mode) begin
      data_d = b_data;
      clk_d  = b_clk;
    end else begin
      data_d = rx_bit;
      clk_d  = ~host_clk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_data <= 1'b0;
      host_clk  <= 1'b0;
    end else if (out_en) begin
      host_data <= data_d;
      host_clk  <= clk_d;
    end
  end
endmodule

// File: rtl/rxpk_check.sv
module rxpk_check #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode,
  input logic          rx_stb,
  input logic          rx_bit,
  input logic          host_data,
  input logic          host_clk,
  input logic          busy,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] len
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!host_clk && !host_data)); // R1
  AST_BIT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && rx_stb) |=> host_data == $past(rx_bit)); // R3
  AST_BIT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && rx_stb) |=> host_clk != $past(host_clk)); // R3
  AST_CNT_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    mode |-> cnt < len); // R4
  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |=> (cnt == '0 && !busy)); // R9
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !busy) |=> !host_clk); // R10
endmodule

bind rx_pkt_buffer rxpk_check #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .rx_stb(rx_stb), .rx_bit(rx_bit),
  .host_data(host_data), .host_clk(host_clk), .busy(busy),
  .cnt(col_cnt), .len(len_dec)
);

// File: tb/rx_pkt_buffer_test.sv
module rx_pkt_buffer_test;
  logic clk, rst_n, rx_bit, rx_stb, cfg_pkt_en, pin_pkt_en;
  logic [1:0] cfg_len, cfg_rate;
  logic host_data, host_clk;

  int checks, fails, cyc, last_rise;
  bit exp_q[$];
  bit pend[$];
  bit prev_clk;
  string cur_req;

  rx_pkt_buffer uut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_stb(rx_stb),
    .cfg_pkt_en(cfg_pkt_en), .pin_pkt_en(pin_pkt_en), .cfg_len(cfg_len),
    .cfg_rate(cfg_rate), .host_data(host_data), .host_clk(host_clk)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int len_of(input logic [1:0] s);
    case (s)
      2'd0: return 16;
      2'd1: return 14;
      2'd2: return 9;
      default: return 8;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input bit b, input int gap);
    @(negedge clk);
    rx_bit = b; rx_stb = 1'b1;
    if (cfg_pkt_en && pin_pkt_en) begin
      pend.push_back(b);
      if (pend.size() == len_of(cfg_len)) begin
        foreach (pend[i]) exp_q.push_back(pend[i]);
        pend.delete();
      end
    end else begin
      exp_q.push_back(b);
    end
    @(negedge clk);
    rx_stb = 1'b0;
    repeat (gap - 2) @(negedge clk);
  endtask

  task automatic set_pin(input bit v);
    @(negedge clk);
    pin_pkt_en = v;
    if (!v) pend.delete();
  endtask

  task automatic send_word(input logic [31:0] w, input int n, input int gap);
    for (int i = 0; i < n; i++) send(w[i], gap);
  endtask

  task automatic drain(input int n);
    repeat (n) @(negedge clk);
    chk({cur_req, " queue drained"}, exp_q.size(), 0);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    cyc++;
    if (rst_n) begin
      bit ev, pm;
      pm = cfg_pkt_en && pin_pkt_en;
      ev = pm ? (host_clk && !prev_clk) : (host_clk != prev_clk);
      if (ev) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL %s unexpected host bit actual=%0d expected=none", cur_req, host_data);
        end else begin
          chk(pm ? {cur_req, " R6 burst bit"} : {cur_req, " R3 bit mode"},
              int'(host_data), int'(exp_q.pop_front()));
        end
        if (pm) begin
          if (cyc - last_rise < 32) chk("R7 burst period", cyc - last_rise, 2 << cfg_rate);
          last_rise = cyc;
        end
      end
    end
    prev_clk = host_clk;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0; cyc = 0; last_rise = -1000; prev_clk = 1'b0;
    rst_n = 1'b0; rx_bit = 1'b0; rx_stb = 1'b0;
    cfg_pkt_en = 1'b0; pin_pkt_en = 1'b0; cfg_len = 2'd3; cfg_rate = 2'd0;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk("R1 host_clk in reset", host_clk, 0);
    chk("R1 host_data in reset", host_data, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 host_clk after reset", host_clk, 0);
    chk("R1 host_data after reset", host_data, 0);

    // R2: pin high but config off -> bit mode
    cur_req = "R2 cfg off";
    pin_pkt_en = 1'b1;
    send_word(32'b101101, 6, 10);
    drain(10);
    // R2: config on but pin low -> bit mode
    cur_req = "R2 pin off";
    cfg_pkt_en = 1'b1; pin_pkt_en = 1'b0;
    send_word(32'b0110, 4, 10);
    drain(10);

    // R4/R6/R7: length 8, rate 0
    cur_req = "R4 len8";
    cfg_len = 2'd3; cfg_rate = 2'd0;
    set_pin(1'b1);
    send_word(32'hA5C3, 16, 20);
    drain(100);
    chk("R10 idle clock low", host_clk, 0);
    set_pin(1'b0);

    // length 9, rate 1
    cur_req = "R4 len9";
    cfg_len = 2'd2; cfg_rate = 2'd1;
    set_pin(1'b1);
    send_word(32'h2D6B5, 18, 20);
    drain(100);
    set_pin(1'b0);

    // length 14, rate 2
    cur_req = "R4 len14";
    cfg_len = 2'd1; cfg_rate = 2'd2;
    set_pin(1'b1);
    send_word(32'h1E4B, 14, 20);
    drain(200);
    set_pin(1'b0);

    // length 16, rate 3, two packets
    cur_req = "R4 len16";
    cfg_len = 2'd0; cfg_rate = 2'd3;
    set_pin(1'b1);
    send_word(32'h93E1_4C7A, 32, 20);
    drain(300);
    set_pin(1'b0);

    // R8: bits keep arriving during the burst (8 bits, 128-cycle burst, 20-cycle spacing)
    cur_req = "R8 overlap";
    cfg_len = 2'd3; cfg_rate = 2'd3;
    set_pin(1'b1);
    send_word(32'h00C3_5A96, 24, 20);
    drain(200);
    set_pin(1'b0);

    // R5: enable boundary
    cur_req = "R5 boundary";
    cfg_rate = 2'd1;
    send_word(32'b10, 2, 10);
    set_pin(1'b1);
    send_word(32'hB4, 8, 12);
    drain(100);
    set_pin(1'b0);

    // R9: flush partial packet
    cur_req = "R9 flush";
    set_pin(1'b1);
    send_word(32'b11111, 5, 12);
    set_pin(1'b0);
    send_word(32'b01, 2, 10);
    set_pin(1'b1);
    send_word(32'h00, 8, 12);
    drain(100);
    chk("R9 final clock low", host_clk, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule